// File: doc/BRIEF.md
# Multi-Transform Result Combiner

This block sits behind four parallel triple-matrix-product lanes. Each lane produces one cross term of a complex product in which the input matrix is real and both coefficient matrices are split into real and imaginary parts. The four cross terms are real·X·real, real·X·imag, imag·X·real and imag·X·imag. A three-bit mode code selects the transform that is being computed. The block then forms the final result from the lanes that the mode uses. It may subtract two lanes, add two lanes, or pass two lanes through unchanged.

The block also drives the select line of the 2:1 multiplexer in front of the second array. That multiplexer chooses either external data or the first array's result. The block registers the combined result and an output-valid flag with one cycle of latency. A new mode code is taken only while no lane is presenting data, so a transform in flight is never re-interpreted.

Top module: `xform_combiner`

## Requirements
- R1: `mode_req` codes: 000 DFT, 001 DCT, 010 DST, 011 one-dimensional DWT, 100 two-dimensional DWT. `act_mode` shows the code in force.
- R2: In DFT mode, `out_re` = rr − ii and `out_im` = ri + ir. A result is produced only when all four lane valids are high.
- R3: Both outputs are LANE_W+1 bits signed, and the sums and differences never wrap. With LANE_W=16, −32768 − 32767 gives −65535 and 32767 + 32767 gives 65534.
- R4: In DCT mode, `out_re` = rr − ii and `out_im` = 0. Only the rr and ii valids are required.
- R5: In DST mode, `out_im` = ri + ir and `out_re` = 0. Only the ri and ir valids are required.
- R6: In both DWT modes, `out_re` is ri sign-extended and `out_im` is ir sign-extended. Only the ri and ir valids are required.
- R7: `feed_sel` is 1 only while `act_mode` is 100 (two-dimensional DWT) and is 0 for every other code.
- R8: While `act_mode` holds a code above 100, the next cycle shows `out_valid` = 0, `out_re` = 0 and `out_im` = 0, whatever the lanes carry.
- R9: `out_valid` rises on the clock edge after the required lane valids are all high. It stays low if any required lane valid is missing.
- R10: `mode_req` is loaded into `act_mode` only on an edge where all four lane valids are low. Otherwise it is ignored.
- R11: While `rst` is high, `act_mode` = 000, `out_valid` = 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 3 | Requested transform code |
| lane_rr | input | LANE_W | realA·X·realB term, signed |
| lane_ri | input | LANE_W | realA·X·imagB term, signed |
| lane_ir | input | LANE_W | imagA·X·realB term, signed |
| lane_ii | input | LANE_W | imagA·X·imagB term, signed |
| lane_vld | input | 4 | Lane valids, bit3 rr, bit2 ri, bit1 ir, bit0 ii |
| act_mode | output | 3 | Mode code in force |
| feed_sel | output | 1 | Second-array input select, 1 = first array result |
| out_re | output | LANE_W+1 | Real / DCT / first DWT output, signed |
| out_im | output | LANE_W+1 | Imaginary / DST / second DWT output, signed |
| out_valid | output | 1 | Result valid |

## Verification
A mode request is due on `act_mode` and `feed_sel` one edge after it is presented with all lanes idle. A lane set produces `out_re`, `out_im` and `out_valid` one edge after it is presented. The bench drives every input on the falling edge and holds it across exactly one rising edge. It then samples on the following falling edge, which is the first point where the registered result is settled. Rejected mode changes and incomplete lane sets are checked one edge after the offending stimulus, before anything else is driven.

// File: rtl/xf_pkg.sv
package xf_pkg;

    typedef enum logic [2:0] {
        XF_DFT  = 3'd0,
        XF_DCT  = 3'd1,
        XF_DST  = 3'd2,
        XF_DWT1 = 3'd3,
        XF_DWT2 = 3'd4
    } xf_mode_e;

    localparam int NUM_LANES = 4;

    // bit order matches lane_vld: rr, ri, ir, ii
    typedef struct packed {
        logic rr;
        logic ri;
        logic ir;
        logic ii;
    } lane_mask_t;

    function automatic logic mode_legal(input logic [2:0] m);
        return m <= 3'(XF_DWT2);
    endfunction

    function automatic lane_mask_t lanes_needed(input logic [2:0] m);
        lane_mask_t k;
        case (m)
            3'(XF_DFT): k = '{rr: 1'b1, ri: 1'b1, ir: 1'b1, ii: 1'b1};
            3'(XF_DCT): k = '{rr: 1'b1, ri: 1'b0, ir: 1'b0, ii: 1'b1};
            3'(XF_DST),
            3'(XF_DWT1),
            3'(XF_DWT2): k = '{rr: 1'b0, ri: 1'b1, ir: 1'b1, ii: 1'b0};
            default:     k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/xf_mode_ctl.sv
module xf_mode_ctl
    import xf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_req,
    input  logic [3:0] lane_vld,
    output logic [2:0] mode_q,
    output logic       legal,
    output lane_mask_t need,
    output logic       feed_sel
);
    logic idle;

    assign idle = (lane_vld == '0);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 3'(XF_DFT);
        else if (idle)
            mode_q <= mode_req;
    end

    assign legal    = mode_legal(mode_q);
    assign need     = lanes_needed(mode_q);
    assign feed_sel = (mode_q == 3'(XF_DWT2));
endmodule

// File: rtl/xf_lane_math.sv
module xf_lane_math
    import xf_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [2:0]               mode,
    input  logic signed [LANE_W-1:0] rr,
    input  logic signed [LANE_W-1:0] ri,
    input  logic signed [LANE_W-1:0] ir,
    input  logic signed [LANE_W-1:0] ii,
    output logic signed [LANE_W:0]   res_re,
    output logic signed [LANE_W:0]   res_im
);
    localparam int OW = LANE_W + 1;

    logic signed [OW-1:0] rr_x, ri_x, ir_x, ii_x;
    logic signed [OW-1:0] diff, sum;

    assign rr_x = OW'(rr);
    assign ri_x = OW'(ri);
    assign ir_x = OW'(ir);
    assign ii_x = OW'(ii);
    assign diff = rr_x - ii_x;
    assign sum  = ri_x + ir_x;

    always_comb begin
        res_re = '0;
        res_im = '0;
        case (mode)
            3'(XF_DFT): begin res_re = diff; res_im = sum;  end
            3'(XF_DCT): begin res_re = diff; res_im = '0;   end
            3'(XF_DST): begin res_re = '0;   res_im = sum;  end
            3'(XF_DWT1),
            3'(XF_DWT2): begin res_re = ri_x; res_im = ir_x; end
            default: begin res_re = '0; res_im = '0; end
        endcase
    end
endmodule

// File: rtl/xf_out_stage.sv
module xf_out_stage
    import xf_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   legal,
    input  lane_mask_t             need,
    input  logic [3:0]             lane_vld,
    input  logic signed [LANE_W:0] nxt_re,
    input  logic signed [LANE_W:0] nxt_im,
    output logic signed [LANE_W:0] out_re,
    output logic signed [LANE_W:0] out_im,
    output logic                   out_valid
);
    logic [NUM_LANES-1:0] need_v;
    logic [NUM_LANES-1:0] have;
    logic                 fire;

    assign need_v = need;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_have
        assign have[g] = lane_vld[g] | ~need_v[g];
    end

    assign fire = legal && (need_v != '0) && (&have);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_re    <= '0;
            out_im    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= fire;
            if (!legal) begin
                out_re <= '0;
                out_im <= '0;
            end else if (fire) begin
                out_re <= nxt_re;
                out_im <= nxt_im;
            end
        end
    end
endmodule

// File: rtl/xform_combiner.sv
module xform_combiner
    import xf_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             mode_req,
    input  logic signed [LANE_W-1:0] lane_rr,
    input  logic signed [LANE_W-1:0] lane_ri,
    input  logic signed [LANE_W-1:0] lane_ir,
    input  logic signed [LANE_W-1:0] lane_ii,
    input  logic [3:0]             lane_vld,
    output logic [2:0]             act_mode,
    output logic                   feed_sel,
    output logic signed [LANE_W:0] out_re,
    output logic signed [LANE_W:0] out_im,
    output logic                   out_valid
);
    logic                   legal;
    lane_mask_t             need;
    logic signed [LANE_W:0] nxt_re, nxt_im;

    xf_mode_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_req),
        .lane_vld (lane_vld),
        .mode_q   (act_mode),
        .legal    (legal),
        .need     (need),
        .feed_sel (feed_sel)
    );

    xf_lane_math #(.LANE_W(LANE_W)) u_math (
        .mode   (act_mode),
        .rr     (lane_rr),
        .ri     (lane_ri),
        .ir     (lane_ir),
        .ii     (lane_ii),
        .res_re (nxt_re),
        .res_im (nxt_im)
    );

    xf_out_stage #(.LANE_W(LANE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .legal     (legal),
        .need      (need),
        .lane_vld  (lane_vld),
        .nxt_re    (nxt_re),
        .nxt_im    (nxt_im),
        .out_re    (out_re),
        .out_im    (out_im),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/xf_combiner_chk.sv
module xf_combiner_chk #(
    parameter int LANE_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             mode_req,
    input logic signed [LANE_W-1:0] lane_rr,
    input logic signed [LANE_W-1:0] lane_ri,
    input logic signed [LANE_W-1:0] lane_ir,
    input logic signed [LANE_W-1:0] lane_ii,
    input logic [3:0]             lane_vld,
    input logic [2:0]             act_mode,
    input logic                   feed_sel,
    input logic signed [LANE_W:0] out_re,
    input logic signed [LANE_W:0] out_im,
    input logic                   out_valid
);
    logic signed [LANE_W:0] xrr, xri, xir, xii;
    assign xrr = (LANE_W+1)'(lane_rr);
    assign xri = (LANE_W+1)'(lane_ri);
    assign xir = (LANE_W+1)'(lane_ir);
    assign xii = (LANE_W+1)'(lane_ii);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 3'd0 && lane_vld == 4'hF) |=> (out_re == $past(xrr) - $past(xii)
                                                 && out_im == $past(xri) + $past(xir)));

    assert_dwt_pass_R6: assert property (@(posedge clk) disable iff (rst)
        ((act_mode == 3'd3 || act_mode == 3'd4) && lane_vld[2] && lane_vld[1])
            |=> (out_valid && out_re == $past(xri) && out_im == $past(xir)));

    assert_feed_sel_R7: assert property (@(posedge clk) disable iff (rst)
        feed_sel |-> (act_mode == 3'd4));

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (act_mode > 3'd4) |=> (!out_valid && out_re == '0 && out_im == '0));

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (lane_vld != 4'h0) |=> $stable(act_mode));

    assert_no_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (lane_vld == 4'h0) |=> !out_valid);
endmodule

bind xform_combiner xf_combiner_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_req  (mode_req),
    .lane_rr   (lane_rr),
    .lane_ri   (lane_ri),
    .lane_ir   (lane_ir),
    .lane_ii   (lane_ii),
    .lane_vld  (lane_vld),
    .act_mode  (act_mode),
    .feed_sel  (feed_sel),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_valid (out_valid)
);

// File: tb/xform_combiner_bench.sv
module xform_combiner_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode_req = '0;
    logic signed [W-1:0] lane_rr = '0, lane_ri = '0, lane_ir = '0, lane_ii = '0;
    logic [3:0] lane_vld = '0;
    logic [2:0] act_mode;
    logic feed_sel;
    logic signed [W:0] out_re, out_im;
    logic out_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xform_combiner #(.LANE_W(W)) u_xform_combiner (
        .clk(clk), .rst(rst), .mode_req(mode_req),
        .lane_rr(lane_rr), .lane_ri(lane_ri), .lane_ir(lane_ir), .lane_ii(lane_ii),
        .lane_vld(lane_vld), .act_mode(act_mode), .feed_sel(feed_sel),
        .out_re(out_re), .out_im(out_im), .out_valid(out_valid)
    );

    typedef struct packed {
        logic [2:0]          mode;
        logic signed [15:0]  rr, ri, ir, ii;
        logic [3:0]          vld;
        logic signed [16:0]  ere, eim;
        logic                ev;
        logic                chk_data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 16'sd100, 16'sd20, 16'sd30, 16'sd40, 4'b1111, 17'sd60, 17'sd50, 1'b1, 1'b1},          // R2
        '{3'd0, -16'sd32768, 16'sd5, 16'sd7, 16'sd32767, 4'b1111, -17'sd65535, 17'sd12, 1'b1, 1'b1},   // R3
        '{3'd1, 16'sd300, 16'sd9, 16'sd9, -16'sd200, 4'b1001, 17'sd500, 17'sd0, 1'b1, 1'b1},           // R4
        '{3'd2, 16'sd0, 16'sd32767, 16'sd32767, 16'sd0, 4'b0110, 17'sd0, 17'sd65534, 1'b1, 1'b1},      // R3 R5
        '{3'd3, 16'sd1, -16'sd5, 16'sd6, 16'sd1, 4'b0110, -17'sd5, 17'sd6, 1'b1, 1'b1},                // R6
        '{3'd4, 16'sd1, 16'sd11, -16'sd12, 16'sd1, 4'b0110, 17'sd11, -17'sd12, 1'b1, 1'b1},            // R6
        '{3'd0, 16'sd5, 16'sd5, 16'sd5, 16'sd5, 4'b1110, 17'sd0, 17'sd0, 1'b0, 1'b0},                  // R9
        '{3'd1, 16'sd5, 16'sd5, 16'sd5, 16'sd5, 4'b0110, 17'sd0, 17'sd0, 1'b0, 1'b0},                  // R9
        '{3'd5, 16'sd77, 16'sd77, 16'sd77, 16'sd77, 4'b1111, 17'sd0, 17'sd0, 1'b0, 1'b1},              // R8
        '{3'd7, -16'sd9, 16'sd3, 16'sd3, 16'sd3, 4'b1111, 17'sd0, 17'sd0, 1'b0, 1'b1}                  // R8
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_lanes();
        lane_vld = '0;
        lane_rr = '0; lane_ri = '0; lane_ir = '0; lane_ii = '0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        idle_lanes();
        mode_req = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mode_req = 3'd2;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(act_mode == 3'd0, "R11", "act_mode", act_mode, 0);
        chk(out_valid == 1'b0, "R11", "out_valid", out_valid, 0);
        chk(out_re == 0 && out_im == 0, "R11", "out_re", out_re, 0);
        chk(feed_sel == 1'b0, "R11", "feed_sel", feed_sel, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            set_mode(TBL[i].mode);
            chk(act_mode == TBL[i].mode, "R1", "act_mode", act_mode, TBL[i].mode);
            chk(feed_sel == (TBL[i].mode == 3'd4), "R7", "feed_sel", feed_sel,
                longint'(TBL[i].mode == 3'd4));
            chk(out_valid == 1'b0, "R9", "out_valid before lanes", out_valid, 0);
            lane_rr = TBL[i].rr; lane_ri = TBL[i].ri;
            lane_ir = TBL[i].ir; lane_ii = TBL[i].ii;
            lane_vld = TBL[i].vld;
            @(negedge clk);
            idle_lanes();
            chk(out_valid == TBL[i].ev, "R9", $sformatf("out_valid vec%0d", i),
                out_valid, TBL[i].ev);
            if (TBL[i].chk_data) begin
                chk(out_re == TBL[i].ere, "R2", $sformatf("out_re vec%0d", i), out_re, TBL[i].ere);
                chk(out_im == TBL[i].eim, "R2", $sformatf("out_im vec%0d", i), out_im, TBL[i].eim);
            end
        end

        // R10: mode change rejected while a lane is valid
        set_mode(3'd1);
        mode_req = 3'd4;
        lane_vld = 4'b0100;
        @(negedge clk);
        chk(act_mode == 3'd1, "R10", "act_mode held", act_mode, 1);
        chk(feed_sel == 1'b0, "R10", "feed_sel held", feed_sel, 0);
        lane_vld = 4'b0000;
        @(negedge clk);
        chk(act_mode == 3'd4, "R10", "act_mode after idle", act_mode, 4);
        chk(feed_sel == 1'b1, "R7", "feed_sel 2-D DWT", feed_sel, 1);

        // R9: back-to-back results, one cycle each
        set_mode(3'd0);
        lane_rr = 16'sd10; lane_ri = 16'sd1; lane_ir = 16'sd2; lane_ii = 16'sd3;
        lane_vld = 4'hF;
        @(negedge clk);
        chk(out_valid && out_re == 7 && out_im == 3, "R2", "first of pair", out_re, 7);
        lane_rr = -16'sd10; lane_ii = 16'sd10;
        @(negedge clk);
        chk(out_valid && out_re == -20, "R2", "second of pair", out_re, -20);
        idle_lanes();
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "valid drops", out_valid, 0);

        // R11: reset during operation
        rst = 1'b1;
        @(negedge clk);
        chk(act_mode == 3'd0 && out_re == 0 && !out_valid, "R11", "mid reset", act_mode, 0);
        rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule